// File: doc/BRIEF.md
# Nesting Interrupt Controller with Status Stack

This block arbitrates interrupt requests for a small processor core. It watches three active-low external request lines and a set of internal request pulses (timer, serial channels). Each external line can be made edge-triggered, where a falling edge is remembered in a pending latch, or level-triggered, where the line is looked at directly and never latched. Software owns an enable mask, a write-only force/clear port that can raise or drop any pending latch, and a mode bit that picks between nested and one-at-a-time servicing.

When a request is accepted, the controller saves two core status words and the current mask on an internal last-in-first-out stack that is seven entries deep. In nested mode it also narrows the mask so that only strictly higher-priority sources remain enabled. It then presents a one-cycle take strobe with a vector address. A return command from the core pops the stack, restores the mask and hands back the saved status words. Pushing onto a full stack drops the entry and raises a sticky overflow flag.

Control runs on three states. RUN is the waiting state. RUN goes to VECTOR on a grant. RUN goes to RETURN on a pop. Both VECTOR and RETURN go back to RUN after one cycle. In every other case RUN stays in RUN. Requests and return commands are evaluated only in RUN.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, take, ret_valid, level and stk_ovf are 0, the mask is 0 (all sources disabled), and every external line is in level mode with sequential servicing.
- R2: With cfg bit k = 1 (edge mode), a high-to-low transition on ext_req_n[k] sets a pending latch. The request is served once even if the line returns high before acceptance.
- R3: With cfg bit k = 0 (level mode), ext_req_n[k] low requests directly without latching. A line that returns high while masked leaves no request behind.
- R4: Fixed priority: external line k is source k, internal input j is source NUM_EXT+j, and the lowest source index wins. The vector is 4 times the winning index.
- R5: A source whose mask bit is 0 is not accepted. Its pending latch is kept until the bit is set again.
- R6: A write with fc_we sets pending for each fc_force bit and clears it for each fc_clear bit. Clear wins when both apply to the same bit.
- R7: take is high for exactly one cycle, the cycle after the grant. Accepting a source clears its pending latch.
- R8: A grant pushes {astat_in, mstat_in, mask} and raises level by one.
- R9: With cfg bit 4 = 1 (nested), a grant of source i leaves only mask bits below i set. A higher-priority source can then be taken while level > 0.
- R10: With cfg bit 4 = 0 (sequential), no grant happens while level > 0. A waiting request is served after the return.
- R11: rti in RUN with level > 0 pops one entry. ret_valid pulses in the next cycle with astat_out/mstat_out restored, the mask is restored and level drops by one. rti at level 0 does nothing.
- R12: A grant with level = 7 leaves level and the stored entries unchanged and sets stk_ovf. stk_ovf stays set until reset.
- R13: When rti and a grant fall in the same RUN cycle, the pop happens and the grant waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | NUM_EXT | External request lines, active low |
| int_req | input | NUM_INT | Internal request pulses, one cycle each |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | CFG_W | Bits [NUM_EXT-1:0] edge select, bit 4 nested mode |
| mask_we | input | 1 | Write strobe for the mask |
| mask_wdata | input | NUM_EXT+NUM_INT | New mask, 1 = enabled |
| fc_we | input | 1 | Strobe for the force/clear write |
| fc_force | input | NUM_EXT+NUM_INT | Force bits, one per source |
| fc_clear | input | NUM_EXT+NUM_INT | Clear bits, one per source |
| astat_in | input | STAT_W | Arithmetic status to save |
| mstat_in | input | STAT_W | Mode status to save |
| rti | input | 1 | Return-from-interrupt command |
| take | output | 1 | One-cycle acceptance strobe |
| vector | output | VEC_W | Vector address, valid with take |
| ret_valid | output | 1 | One-cycle strobe after a pop |
| astat_out | output | STAT_W | Restored arithmetic status |
| mstat_out | output | STAT_W | Restored mode status |
| mask_q | output | NUM_EXT+NUM_INT | Current mask |
| level | output | $clog2(DEPTH+1) | Stack occupancy |
| stk_ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its defaults: three external lines, three internal sources, a seven-entry stack and 16-bit status words. Six sources make every priority position reachable from one force pattern table. A seven-deep stack can be overrun by rewriting the mask between nested grants of source 0, so eight pushes show the dropped entry and the sticky flag. Edge and level modes are both exercised on real line transitions, and the same-cycle collision of return and grant is set up on purpose.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    // Control register bit that selects nested servicing
    localparam int NEST_BIT = 4;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_VECTOR = 2'd1,
        ST_RETURN = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
    parameter int NUM_EXT = 3,
    parameter int NUM_INT = 3,
    localparam int NSRC = NUM_EXT + NUM_INT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_req_n,
    input  logic [NUM_INT-1:0] int_req,
    input  logic [NUM_EXT-1:0] edge_sel,
    input  logic               fc_we,
    input  logic [NSRC-1:0]    fc_force,
    input  logic [NSRC-1:0]    fc_clear,
    input  logic [NSRC-1:0]    acc_onehot,
    output logic [NSRC-1:0]    req_eff
);

    logic [NUM_EXT-1:0] prev_q;
    logic [NSRC-1:0]    pend_q;
    logic [NSRC-1:0]    set_v;
    logic [NSRC-1:0]    lvl_v;
    logic [NSRC-1:0]    frc_v;
    logic [NSRC-1:0]    clr_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= ext_req_n;
    end

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
        assign set_v[g] = edge_sel[g] & prev_q[g] & ~ext_req_n[g];
        assign lvl_v[g] = ~edge_sel[g] & ~ext_req_n[g];
    end

    for (genvar g = 0; g < NUM_INT; g++) begin : g_int
        assign set_v[NUM_EXT+g] = int_req[g];
        assign lvl_v[NUM_EXT+g] = 1'b0;
    end

    assign frc_v = fc_we ? fc_force : '0;
    assign clr_v = fc_we ? fc_clear : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= ((pend_q & ~acc_onehot) | set_v | frc_v) & ~clr_v;
    end

    assign req_eff = pend_q | lvl_v;

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        // R6
        clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fc_we && fc_clear[g]) |=> !pend_q[g]);
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NSRC  = 6,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  req,
    output logic             vld,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                vld = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_stat_stack.sv
module irq_stat_stack #(
    parameter int W     = 38,
    parameter int DEPTH = 7,
    localparam int SPW   = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   top,
    output logic [SPW-1:0] level,
    output logic           ovf
);

    logic [W-1:0] mem [DEPTH];
    logic         full;

    assign full = (level == SPW'(DEPTH));

    always_ff @(posedge clk) begin
        if (push && !full) mem[level[PTR_W-1:0]] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
            ovf   <= 1'b0;
        end else if (push) begin
            if (full) ovf   <= 1'b1;
            else      level <= level + 1'b1;
        end else if (pop && level != '0) begin
            level <= level - 1'b1;
        end
    end

    assign top = (level != '0) ? mem[PTR_W'(level - 1'b1)] : '0;

    // R12
    sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= SPW'(DEPTH));
    // R12
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R12
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (ovf && level == SPW'(DEPTH)));
    // R8
    push_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> level == $past(level) + 1'b1);
    // R11
    pop_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level != '0) |=> level == $past(level) - 1'b1);

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int NUM_EXT = 3,
    parameter int NUM_INT = 3,
    parameter int STAT_W  = 16,
    parameter int DEPTH   = 7,
    parameter int VEC_W   = 8,
    parameter int CFG_W   = 8,
    localparam int NSRC  = NUM_EXT + NUM_INT,
    localparam int IDX_W = $clog2(NSRC),
    localparam int SPW   = $clog2(DEPTH + 1),
    localparam int ENT_W = 2 * STAT_W + NSRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_req_n,
    input  logic [NUM_INT-1:0] int_req,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               mask_we,
    input  logic [NSRC-1:0]    mask_wdata,
    input  logic               fc_we,
    input  logic [NSRC-1:0]    fc_force,
    input  logic [NSRC-1:0]    fc_clear,
    input  logic [STAT_W-1:0]  astat_in,
    input  logic [STAT_W-1:0]  mstat_in,
    input  logic               rti,
    output logic               take,
    output logic [VEC_W-1:0]   vector,
    output logic               ret_valid,
    output logic [STAT_W-1:0]  astat_out,
    output logic [STAT_W-1:0]  mstat_out,
    output logic [NSRC-1:0]    mask_q,
    output logic [SPW-1:0]     level,
    output logic               stk_ovf
);

    ctl_state_e         st_q, st_d;
    logic [NUM_EXT-1:0] edge_q;
    logic               nest_q;
    logic               cfg_unused;
    logic [NSRC-1:0]    req_eff;
    logic [NSRC-1:0]    cand;
    logic               pick_vld;
    logic [IDX_W-1:0]   pick_idx;
    logic [IDX_W-1:0]   win_q;
    logic               seat_free;
    logic               do_grant;
    logic               do_pop;
    logic [NSRC-1:0]    acc_onehot;
    logic [NSRC-1:0]    above_mask;
    logic [ENT_W-1:0]   push_ent;
    logic [ENT_W-1:0]   top_ent;

    assign cfg_unused = ^cfg_wdata;

    // Control register: edge selects and servicing mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
            nest_q <= 1'b0;
        end else if (cfg_we) begin
            edge_q <= cfg_wdata[NUM_EXT-1:0];
            nest_q <= cfg_wdata[NEST_BIT];
        end
    end

    irq_src_latch #(
        .NUM_EXT (NUM_EXT),
        .NUM_INT (NUM_INT)
    ) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_req_n  (ext_req_n),
        .int_req    (int_req),
        .edge_sel   (edge_q),
        .fc_we      (fc_we),
        .fc_force   (fc_force),
        .fc_clear   (fc_clear),
        .acc_onehot (acc_onehot),
        .req_eff    (req_eff)
    );

    assign cand = req_eff & mask_q;

    irq_prio_pick #(
        .NSRC  (NSRC),
        .IDX_W (IDX_W)
    ) u_pick (
        .req (cand),
        .vld (pick_vld),
        .idx (pick_idx)
    );

    assign seat_free  = nest_q || (level == '0);
    assign do_pop     = (st_q == ST_RUN) && rti && (level != '0);
    assign do_grant   = (st_q == ST_RUN) && !rti && pick_vld && seat_free;
    assign acc_onehot = do_grant ? (NSRC'(1) << pick_idx) : '0;
    assign above_mask = (NSRC'(1) << pick_idx) - NSRC'(1);
    assign push_ent   = {astat_in, mstat_in, mask_q};

    irq_stat_stack #(
        .W     (ENT_W),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (do_grant),
        .pop   (do_pop),
        .din   (push_ent),
        .top   (top_ent),
        .level (level),
        .ovf   (stk_ovf)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (do_pop)        st_d = ST_RETURN;
                else if (do_grant) st_d = ST_VECTOR;
                else               st_d = ST_RUN;
            end
            ST_VECTOR: st_d = ST_RUN;
            ST_RETURN: st_d = ST_RUN;
            default:   st_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // Datapath registers updated on state transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q     <= '0;
            mask_q    <= '0;
            astat_out <= '0;
            mstat_out <= '0;
        end else begin
            if (do_grant) win_q <= pick_idx;
            if (do_grant && nest_q) begin
                mask_q <= mask_q & above_mask;
            end else if (do_pop) begin
                mask_q <= top_ent[NSRC-1:0];
            end else if (mask_we) begin
                mask_q <= mask_wdata;
            end
            if (do_pop) begin
                astat_out <= top_ent[ENT_W-1 -: STAT_W];
                mstat_out <= top_ent[NSRC +: STAT_W];
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        take      = 1'b0;
        ret_valid = 1'b0;
        vector    = '0;
        unique case (st_q)
            ST_VECTOR: begin
                take   = 1'b1;
                vector = VEC_W'({win_q, 2'b00});
            end
            ST_RETURN: ret_valid = 1'b1;
            default: ;
        endcase
    end

    // R7
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);
    // R10
    seq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !nest_q && !$past(cfg_we)) |-> level == SPW'(1));
    // R11
    ret_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && rti && level == '0) |=> !ret_valid);
    // R13
    ret_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && rti && level != '0) |=> (ret_valid && !take));

endmodule

// File: tb/irq_nest_ctrl_bench.sv
module irq_nest_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ext_req_n = 3'b111;
    logic [2:0]  int_req = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        mask_we = 1'b0;
    logic [5:0]  mask_wdata = '0;
    logic        fc_we = 1'b0;
    logic [5:0]  fc_force = '0;
    logic [5:0]  fc_clear = '0;
    logic [15:0] astat_in = '0;
    logic [15:0] mstat_in = '0;
    logic        rti = 1'b0;
    logic        take;
    logic [7:0]  vector;
    logic        ret_valid;
    logic [15:0] astat_out;
    logic [15:0] mstat_out;
    logic [5:0]  mask_q;
    logic [2:0]  level;
    logic        stk_ovf;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    irq_nest_ctrl u_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .int_req(int_req),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .fc_we(fc_we), .fc_force(fc_force),
        .fc_clear(fc_clear), .astat_in(astat_in), .mstat_in(mstat_in),
        .rti(rti), .take(take), .vector(vector), .ret_valid(ret_valid),
        .astat_out(astat_out), .mstat_out(mstat_out), .mask_q(mask_q),
        .level(level), .stk_ovf(stk_ovf)
    );

    // {force pattern, expected winning index}
    localparam logic [11:0] VEC_TBL [0:6] = '{
        {6'b000001, 6'd0}, {6'b111110, 6'd1}, {6'b110100, 6'd2},
        {6'b111000, 6'd3}, {6'b110000, 6'd4}, {6'b100000, 6'd5},
        {6'b101010, 6'd1}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_service();
        step();
        rti = 1'b1; step(); rti = 1'b0;
        step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 take", take, 0);
        check("R1 ret_valid", ret_valid, 0);
        check("R1 level", level, 0);
        check("R1 ovf", stk_ovf, 0);
        check("R1 mask", mask_q, 0);

        rti = 1'b1; step(); rti = 1'b0;
        check("R11 empty rti ret_valid", ret_valid, 0);
        check("R11 empty rti level", level, 0);

        cfg_we = 1'b1; cfg_wdata = 8'h07; mask_we = 1'b1; mask_wdata = 6'h3f;
        step();
        cfg_we = 1'b0; mask_we = 1'b0;

        // Table walk: priority and vector
        for (int t = 0; t < 7; t++) begin
            astat_in = 16'hA000 + 16'(t);
            mstat_in = 16'h5000 + 16'(t);
            fc_we = 1'b1; fc_force = VEC_TBL[t][11:6];
            step();
            fc_we = 1'b0; fc_force = '0;
            step();
            check("R4 take", take, 1);
            check("R4 vector", vector, 32'(VEC_TBL[t][5:0]) * 4);
            check("R8 level", level, 1);
            step();
            check("R7 pulse", take, 0);
            rti = 1'b1; step(); rti = 1'b0;
            check("R11 ret_valid", ret_valid, 1);
            check("R11 astat", astat_out, 16'hA000 + 16'(t));
            check("R11 mstat", mstat_out, 16'h5000 + 16'(t));
            check("R11 level", level, 0);
            check("R11 mask", mask_q, 6'h3f);
            fc_we = 1'b1; fc_clear = 6'h3f;
            step();
            fc_we = 1'b0; fc_clear = '0;
            step();
            check("R6 cleared", take, 0);
        end

        // R2 edge latch
        ext_req_n = 3'b110; step();
        ext_req_n = 3'b111; step();
        check("R2 take", take, 1);
        check("R2 vector", vector, 0);
        step();
        rti = 1'b1; step(); rti = 1'b0;
        step(); step();
        check("R2 served once", take, 0);

        // R4 internal source index
        int_req = 3'b010; step(); int_req = '0; step();
        check("R4 internal vector", vector, 16);
        finish_service();

        // R3 level mode on line 1
        cfg_we = 1'b1; cfg_wdata = 8'h05; mask_we = 1'b1; mask_wdata = 6'h3d;
        step();
        cfg_we = 1'b0; mask_we = 1'b0;
        ext_req_n = 3'b101; step(); step();
        check("R5 masked level", take, 0);
        ext_req_n = 3'b111; step();
        mask_we = 1'b1; mask_wdata = 6'h3f; step(); mask_we = 1'b0;
        step(); step();
        check("R3 not latched", take, 0);
        ext_req_n = 3'b101; step();
        check("R3 level take", take, 1);
        check("R3 vector", vector, 4);
        ext_req_n = 3'b111;
        finish_service();

        // R5 mask holds pending
        mask_we = 1'b1; mask_wdata = 6'h3b; fc_we = 1'b1; fc_force = 6'h04;
        step();
        mask_we = 1'b0; fc_we = 1'b0; fc_force = '0;
        step(); step();
        check("R5 blocked", take, 0);
        mask_we = 1'b1; mask_wdata = 6'h3f; step(); mask_we = 1'b0;
        step();
        check("R5 released take", take, 1);
        check("R5 vector", vector, 8);
        finish_service();

        // R6 clear wins over force
        fc_we = 1'b1; fc_force = 6'h08; fc_clear = 6'h08; step();
        fc_we = 1'b0; fc_force = '0; fc_clear = '0;
        step();
        check("R6 clear wins", take, 0);
        mask_we = 1'b1; mask_wdata = 6'h37; fc_we = 1'b1; fc_force = 6'h08; step();
        mask_we = 1'b0; fc_force = '0; fc_clear = 6'h08; step();
        fc_we = 1'b0; fc_clear = '0;
        mask_we = 1'b1; mask_wdata = 6'h3f; step(); mask_we = 1'b0;
        step();
        check("R6 cleared latch", take, 0);

        // R10 sequential servicing
        fc_we = 1'b1; fc_force = 6'h10; step(); fc_we = 1'b0; fc_force = '0;
        step();
        check("R10 first take", vector, 16);
        step();
        fc_we = 1'b1; fc_force = 6'h01; step(); fc_we = 1'b0; fc_force = '0;
        step();
        check("R10 blocked", take, 0);
        step();
        check("R10 still blocked", take, 0);
        rti = 1'b1; step(); rti = 1'b0;
        check("R10 ret", ret_valid, 1);
        step();
        check("R10 no take in return", take, 0);
        step();
        check("R10 deferred take", take, 1);
        check("R10 deferred vector", vector, 0);
        finish_service();

        // R9 nested servicing
        cfg_we = 1'b1; cfg_wdata = 8'h17; step(); cfg_we = 1'b0;
        astat_in = 16'h1111;
        fc_we = 1'b1; fc_force = 6'h08; step(); fc_we = 1'b0; fc_force = '0;
        step();
        check("R9 vector", vector, 12);
        check("R9 mask narrowed", mask_q, 6'h07);
        step();
        fc_we = 1'b1; fc_force = 6'h10; step(); fc_we = 1'b0; fc_force = '0;
        step();
        check("R9 lower blocked", take, 0);
        fc_we = 1'b1; fc_clear = 6'h10; step(); fc_we = 1'b0; fc_clear = '0;
        astat_in = 16'h2222;
        fc_we = 1'b1; fc_force = 6'h02; step(); fc_we = 1'b0; fc_force = '0;
        step();
        check("R9 preempt take", take, 1);
        check("R9 preempt vector", vector, 4);
        check("R9 level", level, 2);
        check("R9 mask inner", mask_q, 6'h01);
        step();
        rti = 1'b1; step(); rti = 1'b0;
        check("R11 nested astat", astat_out, 16'h2222);
        check("R11 nested mask", mask_q, 6'h07);
        check("R11 nested level", level, 1);
        step();

        // R13 return beats grant
        fc_we = 1'b1; fc_force = 6'h01; step(); fc_we = 1'b0; fc_force = '0;
        rti = 1'b1; step(); rti = 1'b0;
        check("R13 no take", take, 0);
        check("R13 ret_valid", ret_valid, 1);
        check("R13 astat", astat_out, 16'h1111);
        check("R13 mask", mask_q, 6'h3f);
        step(); step();
        check("R13 grant after", take, 1);
        check("R13 vector", vector, 0);
        finish_service();

        // R12 overflow
        for (int i = 0; i < 8; i++) begin
            astat_in = 16'h0E00 + 16'(i);
            mask_we = 1'b1; mask_wdata = 6'h3f; fc_we = 1'b1; fc_force = 6'h01;
            step();
            mask_we = 1'b0; fc_we = 1'b0; fc_force = '0;
            step();
            check("R12 take", take, 1);
            check("R12 level", level, (i < 7) ? i + 1 : 7);
            check("R12 ovf", stk_ovf, (i == 7) ? 1 : 0);
            step();
        end
        rti = 1'b1; step(); rti = 1'b0;
        check("R12 dropped entry", astat_out, 16'h0E06);
        check("R12 level after pop", level, 6);
        step();
        for (int i = 0; i < 6; i++) begin
            rti = 1'b1; step(); rti = 1'b0; step();
        end
        check("R12 drained", level, 0);
        check("R12 sticky", stk_ovf, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule